// File: doc/BRIEF.md
# Locality-Gated Measurement Register Bank

This block holds a small bank of measurement registers whose write access is tied to a privilege tag called locality. Every command carries a locality value next to its opcode. Registers are split into three tiers: a general tier open to any locality, a middle tier that needs locality 3 or above, and a top tier that needs locality 4. The block tracks the highest locality currently allowed. That ceiling rises to 4 only when the secure-launch input goes high. After that it can only be lowered, either by a drop command or by the launch input going low, until the next launch or reset.

A measurement is folded into a register with a cheap, non-cryptographic mix: rotate the old value left by 5, then XOR in the command data and a fixed odd constant. A one-word control register stands for the special controls that exist only during the launch phase. It can be written only while the ceiling is 4.

Commands enter on a valid/ready port, and each accepted command produces exactly one response on a valid/ready response port. Back-pressure works as follows. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever no response is pending or the pending response is being taken in that cycle. A response stays valid, with status and data unchanged, until `rsp_ready` is seen high.

Top module: `meas_bank`

## Requirements
- R1: After reset all registers and the control register read as 0, the ceiling is 3, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: A command accepted at an edge yields `rsp_valid` = 1 after that edge. While `rsp_ready` is 0, the response holds its status and data and `cmd_ready` stays 0. The response clears on the first edge where `rsp_ready` is 1.
- R3: Opcodes are 0 read, 1 extend, 2 clear, 3 drop, 4 control write and 5 control read. Opcodes 6 and 7, and a locality above 4, return status 2'b11. Success returns 2'b00 and a refusal returns 2'b10. A command that does not succeed returns data 0 and changes no state.
- R4: Extend sets register[idx] to rotl(old,5) ^ data ^ 32'h9E3779B9 and returns the new value. Read returns the value and changes nothing. Clear sets the register to 0 and returns 0.
- R5: Extend and clear need a locality of at least 0 for registers 0–3, at least 3 for registers 4–5, and 4 for registers 6–7. A lower locality is refused.
- R6: A command tagged locality 4 while `launch_i` is low returns 2'b11.
- R7: Any command whose locality is above the current ceiling is refused (2'b10). This includes locality 4 once the ceiling has been lowered during a launch.
- R8: A rising edge of `launch_i` sets the ceiling to 4. While `launch_i` is low the ceiling is at most 3. The ceiling never rises otherwise.
- R9: Drop takes its target in `cmd_idx`. A target above 4 returns 2'b11. A target above the ceiling is refused. Otherwise the ceiling becomes the target and the target is returned as data.
- R10: Control write needs locality 4, which requires the ceiling to be 4. It stores `cmd_data[CW-1:0]` and returns it; otherwise it is refused. Control read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_i | input | 1 | Secure-launch mode |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_op | input | 3 | Opcode |
| cmd_loc | input | LW (3) | Locality tag |
| cmd_idx | input | IW (3) | Register index or drop target |
| cmd_data | input | DW (32) | Extend or control-write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_status | output | 2 | 00 ok, 10 refused, 11 malformed |
| rsp_data | output | DW (32) | Response data |

## Verification
The bench builds the block with its defaults: eight 32-bit registers (IW = 3), a 3-bit locality and an 8-bit control register. That puts all three permission tiers in reach, along with the out-of-range localities 5–7 and the drop targets 5–7. Seeded random commands run between launch pulses, so the ceiling is raised, dropped and capped many times. Directed cases cover the launch order, the locked control register and a held response.

// File: rtl/meas_pkg.sv
package meas_pkg;
  localparam logic [2:0] OP_READ    = 3'd0;
  localparam logic [2:0] OP_EXTEND  = 3'd1;
  localparam logic [2:0] OP_CLEAR   = 3'd2;
  localparam logic [2:0] OP_DROP    = 3'd3;
  localparam logic [2:0] OP_CTRL_WR = 3'd4;
  localparam logic [2:0] OP_CTRL_RD = 3'd5;

  localparam logic [1:0] ST_OK   = 2'b00;
  localparam logic [1:0] ST_DENY = 2'b10;
  localparam logic [1:0] ST_BAD  = 2'b11;

  localparam int LOC_TOP  = 4;
  localparam int LOC_IDLE = 3;

  typedef struct packed {
    logic [1:0] status;
    logic       ext;
    logic       clr;
    logic       drop;
    logic       ctrl_wr;
  } verdict_t;

  // Minimum locality per register tier: lower half general, next quarter
  // mid tier, top quarter launch-only.
  function automatic int min_loc(int idx, int nreg);
    if (idx < nreg / 2)            return 0;
    else if (idx < (nreg * 3) / 4) return 3;
    else                           return 4;
  endfunction
endpackage

// File: rtl/meas_loc_track.sv
module meas_loc_track #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic          drop_en,
  input  logic [LW-1:0] drop_lvl,
  output logic [LW-1:0] lvl_o
);
  import meas_pkg::*;

  logic          launch_q;
  logic [LW-1:0] lvl_q;
  logic [LW-1:0] lvl_nxt;

  always_comb begin
    lvl_nxt = drop_en ? drop_lvl : lvl_q;
    if (launch_i && !launch_q)
      lvl_nxt = LW'(LOC_TOP);
    else if (!launch_i && int'(lvl_nxt) > LOC_IDLE)
      lvl_nxt = LW'(LOC_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launch_q <= 1'b0;
      lvl_q    <= LW'(LOC_IDLE);
    end else begin
      launch_q <= launch_i;
      lvl_q    <= lvl_nxt;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/meas_decide.sv
module meas_decide #(
  parameter int NREG = 8,
  parameter int LW   = 3,
  parameter int IW   = 3
) (
  input  logic [2:0]          op,
  input  logic [LW-1:0]       loc,
  input  logic [IW-1:0]       idx,
  input  logic [LW-1:0]       lvl,
  input  logic                launch_i,
  output meas_pkg::verdict_t  v
);
  import meas_pkg::*;

  logic bad;
  int   need;

  always_comb begin
    need = min_loc(int'(idx), NREG);
    bad  = (op > OP_CTRL_RD) || (int'(loc) > LOC_TOP) ||
           (int'(loc) == LOC_TOP && !launch_i) ||
           (op == OP_DROP && int'(idx) > LOC_TOP);
    v = '0;
    if (bad) begin
      v.status = ST_BAD;
    end else if (loc > lvl) begin
      v.status = ST_DENY;
    end else begin
      v.status = ST_OK;
      case (op)
        OP_EXTEND, OP_CLEAR: begin
          if (int'(loc) < need) v.status = ST_DENY;
          else if (op == OP_EXTEND) v.ext = 1'b1;
          else v.clr = 1'b1;
        end
        OP_DROP: begin
          if (int'(idx) > int'(lvl)) v.status = ST_DENY;
          else v.drop = 1'b1;
        end
        OP_CTRL_WR: begin
          if (int'(loc) != LOC_TOP) v.status = ST_DENY;
          else v.ctrl_wr = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/meas_regfile.sv
module meas_regfile #(
  parameter int          NREG = 8,
  parameter int          DW   = 32,
  parameter int          IW   = 3,
  parameter int          ROT  = 5,
  parameter logic [31:0] SALT = 32'h9E3779B9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext,
  input  logic               clr,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      data,
  output logic [DW-1:0]      rd_val,
  output logic [DW-1:0]      mix_val,
  output logic [NREG*DW-1:0] bank_o
);
  logic [DW-1:0] regs [NREG];

  assign rd_val  = regs[idx];
  assign mix_val = ((rd_val << ROT) | (rd_val >> (DW - ROT))) ^ data ^ DW'(SALT);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic sel;
    assign sel = (ext || clr) && (int'(idx) == g);
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[g] <= '0;
      else if (sel) regs[g] <= clr ? '0 : mix_val;
    end
    assign bank_o[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/meas_bank.sv
module meas_bank #(
  parameter int          IW   = 3,
  parameter int          DW   = 32,
  parameter int          LW   = 3,
  parameter int          CW   = 8,
  parameter int          ROT  = 5,
  parameter logic [31:0] SALT = 32'h9E3779B9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_loc,
  input  logic [IW-1:0] cmd_idx,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_data
);
  import meas_pkg::*;

  localparam int NREG = 2 ** IW;

  logic               fire;
  verdict_t           vd;
  logic [LW-1:0]      lvl_q;
  logic [DW-1:0]      rd_val;
  logic [DW-1:0]      mix_val;
  logic [NREG*DW-1:0] bank_flat;
  logic [CW-1:0]      ctrl_q;
  logic [DW-1:0]      ok_data;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  meas_decide #(.NREG(NREG), .LW(LW), .IW(IW)) decide_i (
    .op(cmd_op), .loc(cmd_loc), .idx(cmd_idx), .lvl(lvl_q),
    .launch_i(launch_i), .v(vd)
  );

  meas_loc_track #(.LW(LW)) track_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_i),
    .drop_en(fire && vd.drop), .drop_lvl(LW'(cmd_idx)), .lvl_o(lvl_q)
  );

  meas_regfile #(.NREG(NREG), .DW(DW), .IW(IW), .ROT(ROT), .SALT(SALT)) rf_i (
    .clk(clk), .rst_n(rst_n), .ext(fire && vd.ext), .clr(fire && vd.clr),
    .idx(cmd_idx), .data(cmd_data), .rd_val(rd_val), .mix_val(mix_val),
    .bank_o(bank_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  ctrl_q <= '0;
    else if (fire && vd.ctrl_wr) ctrl_q <= cmd_data[CW-1:0];
  end

  always_comb begin
    case (cmd_op)
      OP_READ:    ok_data = rd_val;
      OP_EXTEND:  ok_data = mix_val;
      OP_DROP:    ok_data = DW'(cmd_idx);
      OP_CTRL_WR: ok_data = DW'(cmd_data[CW-1:0]);
      OP_CTRL_RD: ok_data = DW'(ctrl_q);
      default:    ok_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_data   <= '0;
    end else if (fire) begin
      rsp_valid  <= 1'b1;
      rsp_status <= vd.status;
      rsp_data   <= (vd.status == ST_OK) ? ok_data : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/meas_bank_chk.sv
module meas_bank_chk #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int LW   = 3,
  parameter int CW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               launch_i,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [LW-1:0]      cmd_loc,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [1:0]         rsp_status,
  input logic [DW-1:0]      rsp_data,
  input logic [LW-1:0]      lvl,
  input logic [NREG*DW-1:0] bank,
  input logic [CW-1:0]      ctrl
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_data)));

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);

  p_loc4_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && int'(cmd_loc) == 4 && !launch_i) |=> (rsp_status == 2'b11));

  p_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> ((rsp_status == 2'b00) || ($stable(bank) && $stable(ctrl))));

  p_lvl_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl) <= 4);

  p_lvl_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl > $past(lvl)) |-> (int'(lvl) == 4 && $past(launch_i)));

  p_launch_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_i |=> (int'(lvl) <= 3));

  p_ctrl_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lvl) != 4 && int'($past(lvl)) != 4) |-> $stable(ctrl));
endmodule

bind meas_bank meas_bank_chk #(.NREG(NREG), .DW(DW), .LW(LW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_loc(cmd_loc), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_data(rsp_data),
  .lvl(lvl_q), .bank(bank_flat), .ctrl(ctrl_q)
);

// File: tb/meas_bank_tb.sv
module meas_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_i = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_loc = '0;
  logic [2:0]  cmd_idx = '0;
  logic [31:0] cmd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_reg [8];
  logic [7:0]  m_ctrl;
  int          m_lvl;
  logic        m_launch;

  always #4 clk = ~clk;

  meas_bank dut_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_loc(cmd_loc), .cmd_idx(cmd_idx),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] mix_f(logic [31:0] o, logic [31:0] d);
    return {o[26:0], o[31:27]} ^ d ^ 32'h9E3779B9;
  endfunction

  function automatic int need_f(int idx);
    if (idx < 4) return 0;
    if (idx < 6) return 3;
    return 4;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(int op, int loc, int idx, logic [31:0] d, string tag);
    logic [1:0]  es;
    logic [31:0] ed;
    es = 2'b00;
    ed = 32'h0;
    if (op > 5 || loc > 4 || (loc == 4 && !m_launch) || (op == 3 && idx > 4)) es = 2'b11;
    else if (loc > m_lvl) es = 2'b10;
    else begin
      case (op)
        0: ed = m_reg[idx];
        1: if (loc < need_f(idx)) es = 2'b10; else ed = mix_f(m_reg[idx], d);
        2: if (loc < need_f(idx)) es = 2'b10;
        3: if (idx > m_lvl) es = 2'b10; else ed = 32'(idx);
        4: if (loc != 4) es = 2'b10; else ed = {24'h0, d[7:0]};
        default: ed = {24'h0, m_ctrl};
      endcase
    end
    @(negedge clk);
    cmd_op = 3'(op); cmd_loc = 3'(loc); cmd_idx = 3'(idx); cmd_data = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " status"}, {62'h0, rsp_status}, {62'h0, es});
    chk({tag, " data"}, {32'h0, rsp_data}, {32'h0, ed});
    if (es == 2'b00) begin
      case (op)
        1: m_reg[idx] = ed;
        2: m_reg[idx] = 32'h0;
        3: m_lvl = idx;
        4: m_ctrl = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic set_launch(logic v);
    @(negedge clk);
    launch_i = v;
    @(negedge clk);
    if (v && !m_launch) m_lvl = 4;
    else if (!v && m_lvl > 3) m_lvl = 3;
    m_launch = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    int unsigned seed;
    for (int i = 0; i < 8; i++) m_reg[i] = 32'h0;
    m_ctrl = 8'h0; m_lvl = 3; m_launch = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    chk("R1 cmd_ready", {63'h0, cmd_ready}, 64'h1);
    for (int i = 0; i < 8; i++) run_cmd(0, 0, i, 32'h0, "R1");
    run_cmd(5, 0, 0, 32'h0, "R1");

    // R4 extend/read/clear in general tier
    run_cmd(1, 0, 1, 32'h12345678, "R4");
    run_cmd(1, 2, 1, 32'hFFFF0000, "R4");
    run_cmd(0, 1, 1, 32'h0, "R4");
    run_cmd(2, 3, 1, 32'h0, "R4");
    run_cmd(0, 0, 1, 32'h0, "R4");
    // R3 malformed
    run_cmd(6, 0, 0, 32'h1, "R3");
    run_cmd(7, 0, 0, 32'h1, "R3");
    run_cmd(1, 5, 0, 32'h1, "R3");
    // R5 tiers outside launch
    run_cmd(1, 2, 4, 32'hAA, "R5");
    run_cmd(1, 3, 5, 32'hBB, "R5");
    run_cmd(2, 3, 6, 32'h0, "R5");
    // R6 locality 4 without launch
    run_cmd(0, 4, 0, 32'h0, "R6");
    run_cmd(4, 4, 0, 32'h5A, "R6");
    // R10 control locked outside launch
    run_cmd(4, 3, 0, 32'h33, "R10");

    // R8 launch sequence
    set_launch(1'b1);
    run_cmd(1, 4, 6, 32'hC0FFEE00, "R8");
    run_cmd(4, 4, 0, 32'hA5, "R10");
    run_cmd(5, 0, 0, 32'h0, "R10");
    run_cmd(3, 4, 3, 32'h0, "R9");
    run_cmd(1, 3, 4, 32'h0BADF00D, "R9");
    run_cmd(1, 4, 7, 32'h1, "R7");
    run_cmd(4, 4, 0, 32'h11, "R7");
    run_cmd(4, 3, 0, 32'h11, "R10");
    run_cmd(3, 3, 4, 32'h0, "R9");
    run_cmd(3, 3, 6, 32'h0, "R9");
    run_cmd(3, 2, 1, 32'h0, "R9");
    run_cmd(1, 2, 2, 32'h77, "R7");
    run_cmd(0, 3, 0, 32'h0, "R7");
    set_launch(1'b0);
    run_cmd(0, 1, 6, 32'h0, "R7");
    set_launch(1'b1);
    run_cmd(0, 4, 6, 32'h0, "R8");
    set_launch(1'b0);
    run_cmd(0, 3, 0, 32'h0, "R8");
    run_cmd(0, 4, 0, 32'h0, "R6");

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_op = 3'd0; cmd_loc = 3'd0; cmd_idx = 3'd6; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    held = rsp_data;
    chk("R2 valid", {63'h0, rsp_valid}, 64'h1);
    chk("R2 data", {32'h0, held}, {32'h0, m_reg[6]});
    chk("R2 stall", {63'h0, cmd_ready}, 64'h0);
    repeat (2) @(negedge clk);
    chk("R2 held valid", {63'h0, rsp_valid}, 64'h1);
    chk("R2 held data", {32'h0, rsp_data}, {32'h0, held});
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 drained", {63'h0, rsp_valid}, 64'h0);
    chk("R2 ready", {63'h0, cmd_ready}, 64'h1);

    // Random mix
    seed = $urandom(32'd2024);
    for (int n = 0; n < 600; n++) begin
      if (n % 37 == 0) set_launch(1'($urandom % 2));
      run_cmd(int'($urandom % 8), int'($urandom % 6), int'($urandom % 8), $urandom, "R3 random");
    end
    for (int i = 0; i < 8; i++) run_cmd(0, 0, i, 32'h0, "R4 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule